// File: doc/BRIEF.md
# Single-Item Coin Credit Controller

This block is the sequencing core of a one-product vending machine whose item costs 15 currency units. Every clock cycle it samples a 2-bit coin code, adds the coin's value to the credit held in a small state register, and decides at once whether the item is bought and how much change is paid out. The outputs are Mealy outputs, so a purchase strobe and its change code appear in the same cycle as the coin that completes the price.

The controller never holds more than 10 units. Any payment that reaches the price buys the item and clears the credit. Any overpayment is returned as change, up to 15 units. If a cycle carries no coin while some credit is held, that credit is refunded in full and the machine goes back to zero. A synchronous active-high reset clears the credit and silences both outputs.

The decision stage has two build-time variants that behave the same way. One is an arithmetic form that adds the coin to the credit and compares the sum with the price. The other is a flat lookup over every state and coin pair.

Top module: `vend_fsm`

## Requirements
- R1: Coin codes are 00 = none, 01 = 5, 10 = 10, 11 = 20 units. Credit codes are 00 = 0, 01 = 5, 10 = 10 units. A coin that leaves the total below 15 raises the credit (0+5 gives 01, 0+10 gives 10, 5+5 gives 10), with buy low and change 00.
- R2: With zero credit, a 20-unit coin raises buy with change 01, and the credit stays at 00.
- R3: With 5 credit, a 10-unit coin buys with change 00 and a 20-unit coin buys with change 10. Both return the credit to 00.
- R4: With 10 credit, coins of 5, 10 and 20 units each buy, with change 00, 01 and 11 respectively. The credit returns to 00.
- R5: A no-coin cycle refunds the held credit as change (01 from 5 credit, 10 from 10 credit) with buy low, and the credit returns to 00. At zero credit, a no-coin cycle gives buy low and change 00.
- R6: Change codes are 00 = none, 01 = 5, 10 = 10, 11 = 15 units. Buy and change are functions of the present credit and the present coin within the same cycle, so they last one cycle only.
- R7: The unused credit code 11 leads to credit 00 with buy low and change 00.
- R8: While rst is high, buy is low and change is 00 whatever the coin, and the clock edge sets the credit to 00.
- R9: The arithmetic and lookup variants of the decision stage produce identical results for every credit and coin pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_code | input | COIN_BITS (2) | Coin presented this cycle |
| buy | output | 1 | Item purchase strobe for this cycle |
| change_code | output | CHANGE_BITS (2) | Change paid out this cycle |

## Verification
The assertions take for granted that coin_code carries exactly one coin per cycle, that it is steady around the rising edge, and that rst is asserted for at least one edge before coins arrive, so the credit register starts from a known code. The bench drives coins and reset only on falling edges, and it opens with a reset cycle. It covers every credit and coin pair by first reaching each credit level through real coins. It then runs a long pseudo-random coin stream with resets mixed in. The unused credit code cannot be reached from the ports, so it is covered by driving the decision stage directly.

// File: rtl/vend_pkg.sv
package vend_pkg;

   localparam int COIN_W      = 2;
   localparam int CRED_W      = 2;
   localparam int CHG_W       = 2;
   localparam int PRICE_STEPS = 3;   // price in 5-unit steps

   typedef enum logic [COIN_W-1:0] {
      COIN_NONE = 2'b00,
      COIN_5    = 2'b01,
      COIN_10   = 2'b10,
      COIN_20   = 2'b11
   } coin_e;

   typedef enum logic [CRED_W-1:0] {
      CR_0   = 2'b00,
      CR_5   = 2'b01,
      CR_10  = 2'b10,
      CR_BAD = 2'b11
   } credit_e;

   typedef struct packed {
      credit_e          nxt;
      logic             buy;
      logic [CHG_W-1:0] chg;
   } step_t;

   // value of a coin in 5-unit steps
   function automatic logic [3:0] coin_steps(input logic [COIN_W-1:0] c);
      case (c)
         COIN_5:  coin_steps = 4'd1;
         COIN_10: coin_steps = 4'd2;
         COIN_20: coin_steps = 4'd4;
         default: coin_steps = 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/vend_decide.sv
module vend_decide
   import vend_pkg::*;
#(
   parameter bit USE_ARITH = 1'b1
) (
   input  credit_e           cur,
   input  logic [COIN_W-1:0] coin,
   output step_t             res
);

   generate
      if (USE_ARITH) begin : g_arith
         logic [3:0] total;
         logic [1:0] surplus;
         always_comb begin
            total   = {2'b00, cur} + coin_steps(coin);
            surplus = 2'(total - 4'(PRICE_STEPS));
            res     = '{nxt: CR_0, buy: 1'b0, chg: '0};
            if (cur == CR_BAD) begin
               res = '{nxt: CR_0, buy: 1'b0, chg: '0};
            end else if (coin == COIN_NONE) begin
               res.chg = cur;
            end else if (total >= 4'(PRICE_STEPS)) begin
               res.buy = 1'b1;
               res.chg = surplus;
            end else begin
               res.nxt = credit_e'(total[1:0]);
            end
         end
      end else begin : g_table
         always_comb begin
            case ({cur, coin})
               4'b00_00: res = step_t'(5'b00_0_00);
               4'b00_01: res = step_t'(5'b01_0_00);
               4'b00_10: res = step_t'(5'b10_0_00);
               4'b00_11: res = step_t'(5'b00_1_01);
               4'b01_00: res = step_t'(5'b00_0_01);
               4'b01_01: res = step_t'(5'b10_0_00);
               4'b01_10: res = step_t'(5'b00_1_00);
               4'b01_11: res = step_t'(5'b00_1_10);
               4'b10_00: res = step_t'(5'b00_0_10);
               4'b10_01: res = step_t'(5'b00_1_00);
               4'b10_10: res = step_t'(5'b00_1_01);
               4'b10_11: res = step_t'(5'b00_1_11);
               default:  res = step_t'(5'b00_0_00);
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
   import vend_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  credit_e d,
   output credit_e q
);

   always_ff @(posedge clk) begin
      if (rst) q <= CR_0;
      else     q <= d;
   end

endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
   import vend_pkg::*;
#(
   parameter bit USE_ARITH   = 1'b1,
   parameter int COIN_BITS   = 2,
   parameter int CHANGE_BITS = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [COIN_BITS-1:0]   coin_code,
   output logic                   buy,
   output logic [CHANGE_BITS-1:0] change_code
);

   generate
      if (COIN_BITS != COIN_W) begin : g_bad_coin_w
         $error("vend_fsm: COIN_BITS must equal the coin code width");
      end
      if (CHANGE_BITS != CHG_W) begin : g_bad_chg_w
         $error("vend_fsm: CHANGE_BITS must equal the change code width");
      end
   endgenerate

   credit_e credit_q;
   step_t   decision;

   vend_decide #(.USE_ARITH(USE_ARITH)) u_decide (
      .cur  (credit_q),
      .coin (coin_code),
      .res  (decision)
   );

   vend_credit_reg u_reg (
      .clk (clk),
      .rst (rst),
      .d   (decision.nxt),
      .q   (credit_q)
   );

   // reset silences the Mealy outputs in the same cycle
   assign buy         = decision.buy & ~rst;
   assign change_code = rst ? '0 : decision.chg;

endmodule

// File: rtl/vend_fsm_chk.sv
module vend_fsm_chk (
   input logic       clk,
   input logic       rst,
   input logic [1:0] coin,
   input logic       buy,
   input logic [1:0] chg,
   input logic [1:0] credit
);

   // R8
   always @(posedge clk) begin
      if (rst) begin
         reset_quiet_chk: assert (!buy && chg == 2'b00)
            else $error("outputs active during reset");
      end
   end

   // R3 R4
   buy_clears_chk: assert property (@(posedge clk) disable iff (rst)
      buy |=> credit == 2'b00);

   // R5
   refund_idle_only_chk: assert property (@(posedge clk) disable iff (rst)
      (chg != 2'b00 && !buy) |-> coin == 2'b00);

   // R5
   no_coin_no_buy_chk: assert property (@(posedge clk) disable iff (rst)
      coin == 2'b00 |-> !buy);

   // R7
   legal_credit_chk: assert property (@(posedge clk) disable iff (rst)
      credit != 2'b11);

   // R4
   small_coin_exact_chk: assert property (@(posedge clk) disable iff (rst)
      (buy && coin == 2'b01) |-> chg == 2'b00);

   // R1
   below_price_chk: assert property (@(posedge clk) disable iff (rst)
      (!buy && coin != 2'b00) |-> chg == 2'b00);

endmodule

bind vend_fsm vend_fsm_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .coin   (coin_code),
   .buy    (buy),
   .chg    (change_code),
   .credit (credit_q)
);

// File: tb/sim_vend_fsm.sv
module sim_vend_fsm;
   import vend_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] coin = 2'b00;
   logic       buy0, buy1;
   logic [1:0] chg0, chg1;

   credit_e    dcur = CR_0;
   logic [1:0] dcoin = 2'b00;
   step_t      res_ar, res_tb;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [1:0] mstate = 2'b00;

   always #(CLK_PERIOD/2) clk = ~clk;

   vend_fsm #(.USE_ARITH(1'b1)) u0 (
      .clk(clk), .rst(rst), .coin_code(coin), .buy(buy0), .change_code(chg0));
   vend_fsm #(.USE_ARITH(1'b0)) u1 (
      .clk(clk), .rst(rst), .coin_code(coin), .buy(buy1), .change_code(chg1));

   vend_decide #(.USE_ARITH(1'b1)) d_ar (.cur(dcur), .coin(dcoin), .res(res_ar));
   vend_decide #(.USE_ARITH(1'b0)) d_tb (.cur(dcur), .coin(dcoin), .res(res_tb));

   // reference: credit arithmetic in currency units, result {next, buy, change}
   function automatic logic [4:0] model(input logic [1:0] st, input logic [1:0] cn);
      int cred, val, tot;
      logic [1:0] n, c;
      logic b;
      val = (cn == 2'd0) ? 0 : (cn == 2'd1) ? 5 : (cn == 2'd2) ? 10 : 20;
      n = 2'b00; b = 1'b0; c = 2'b00;
      if (st != 2'b11) begin
         cred = int'(st) * 5;
         if (cn == 2'b00) begin
            c = 2'(cred / 5);
         end else begin
            tot = cred + val;
            if (tot >= 15) begin
               b = 1'b1;
               c = 2'((tot - 15) / 5);
            end else begin
               n = 2'(tot / 5);
            end
         end
      end
      return {n, b, c};
   endfunction

   task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%b exp=%b", tag, act, exp);
      end
   endtask

   // one cycle: drive on falling edge, compare Mealy outputs of both tops
   task automatic step(input logic [1:0] cn, input logic r, input string tag);
      logic [4:0] m;
      logic [4:0] exp;
      @(negedge clk);
      coin = cn;
      rst  = r;
      #1;
      m   = model(mstate, cn);
      exp = r ? 5'b00000 : {2'b00, m[2:0]};
      chk(tag, {2'b00, buy0, chg0}, exp);
      chk({tag, " lookup"}, {2'b00, buy1, chg1}, exp);
      mstate = r ? 2'b00 : m[4:3];
   endtask

   function automatic string tag_for(input int s, input int c);
      if (c == 0)      return "R5";
      else if (s == 0) return (c == 3) ? "R2" : "R1";
      else if (s == 1) return (c == 1) ? "R1" : "R3";
      else             return "R4";
   endfunction

   initial begin
      logic [7:0] lf;
      logic [4:0] m;

      // R8: reset quiets outputs even with a coin present
      step(2'b11, 1'b1, "R8 reset with coin");
      step(2'b00, 1'b0, "R8 idle after reset");

      // R7 R9: decision stage, every credit and coin pair, both variants
      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 4; c++) begin
            dcur  = credit_e'(2'(s));
            dcoin = 2'(c);
            #1;
            m = model(2'(s), 2'(c));
            chk((s == 3) ? "R7 arith" : "R9 arith", res_ar, m);
            chk((s == 3) ? "R7 lookup" : "R9 lookup", res_tb, m);
         end
      end

      // R1-R5 exhaustive: reach each credit level, apply coin, then expose next credit
      for (int s = 0; s < 3; s++) begin
         for (int c = 0; c < 4; c++) begin
            step(2'b00, 1'b1, "R8 reset");
            if (s == 1) step(2'b01, 1'b0, "R1 to five");
            if (s == 2) step(2'b10, 1'b0, "R1 to ten");
            step(2'(c), 1'b0, tag_for(s, c));
            step(2'b00, 1'b0, "R6 next cycle");
         end
      end

      // R6: outputs follow coin within a cycle, gone the next cycle
      step(2'b00, 1'b1, "R8 reset");
      step(2'b11, 1'b0, "R2 overpay");
      step(2'b00, 1'b0, "R6 strobe single cycle");
      step(2'b01, 1'b0, "R1 five");
      step(2'b01, 1'b0, "R1 five more");
      step(2'b11, 1'b0, "R4 max change");
      step(2'b00, 1'b0, "R6 strobe single cycle");

      // R6 R8: pseudo-random multi-coin stream with occasional reset
      lf = 8'hA5;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         step(lf[1:0], (i % 37) == 36, ((i % 37) == 36) ? "R8 mid-stream" : "R6 stream");
      end

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule